// File: doc/BRIEF.md
# Polled Interrupt Status Unit

This block is the polled-mode corner of an interrupt controller. Two timers, two DMA channels and a parameterised group of external lines raise level requests. These are captured into pending flip-flops. Each source has its own mask input. Software never takes a vectored interrupt from this unit. Instead it reads a status word that names the most urgent pending, unmasked and unblocked source, then dispatches the handler itself.

There are three read-only registers behind a small read port. The first is a mask summary for the on-chip sources. The second is a status word that can be read any number of times without side effects. The third carries the same word, but reading it acknowledges the reported source: the source moves from pending to in service, and the word advances to the next candidate. A one-cycle end-of-interrupt pulse retires the most urgent in-service source.

Top module: `pic_poll_unit`

## Requirements
- R1: A request input that is high for a single clock is remembered as pending until that source is acknowledged, even after the input drops.
- R2: Reading address 0 returns the mask summary, a 1 meaning masked. The bit layout is: bit 0 is timer 0, bit 2 is DMA 0, bit 3 is DMA 1 and bit 4 is timer 1. Bit 1 and bits 15:5 read 0, and external masks do not appear.
- R3: The poll word has bit 15 set when a source is reported, bits 4:0 holding that source's type code and bits 14:5 at 0. With nothing to report the word is 0x0000.
- R4: Priority runs from highest to lowest as timer 0, timer 1, DMA 0, DMA 1, then external 0 upward. The default type codes are timer 0 = 8, timer 1 = 18, DMA 0 = 10, DMA 1 = 11 and external n = 12+n. Source index order is tmr0, tmr1, dma0, dma1, ext0..ext3 on bits 0..7.
- R5: A masked pending source is not reported. It stays pending and is reported once its mask clears.
- R6: No source is reported while it, or any source of equal or higher priority, is in service.
- R7: Reading the status address (1) returns the same word as the poll address (2) and changes no state.
- R8: A read of the poll address (2) while a source is reported clears that source's pending bit and sets its in-service bit. From the next cycle the word shows the next eligible source. No other output reacts.
- R9: A request arriving in the same cycle as the acknowledge of a different source stays pending.
- R10: An end-of-interrupt pulse clears only the highest-priority in-service bit.
- R11: A poll read while nothing is reported returns 0x0000 and alters no state.
- R12: Reset clears all pending and in-service state, so the poll word reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NSRC (8) | Level requests, bit order as in R4 |
| mask_i | input | NSRC (8) | Per-source mask, 1 = masked |
| eoi_i | input | 1 | End-of-interrupt pulse |
| rd_en_i | input | 1 | Read strobe; with address 2 it acknowledges |
| rd_addr_i | input | 2 | 0 mask summary, 1 status, 2 poll, 3 reads 0 |
| rd_data_o | output | 16 | Read data, combinational from address and state |

## Verification
A wrong pending or in-service bit shows up in the poll word on the very next read. A lost request vanishes from the word, a stuck in-service bit silences every lower source, and a misplaced acknowledge leaves the same type code reported one cycle later. The vector walk reads the status after every step, so each such fault appears within one clock of the step that causes it. The directed tests then cover the mask layout, repeated non-destructive reads, empty polls and reset.

// File: rtl/pic_poll_pkg.sv
package pic_poll_pkg;
    localparam int TYPE_W = 5;
    localparam int WORD_W = 16;
    localparam int N_ONCHIP = 4;

    typedef enum logic [1:0] {
        RA_MASK = 2'd0,
        RA_STAT = 2'd1,
        RA_POLL = 2'd2,
        RA_NONE = 2'd3
    } rd_addr_e;
endpackage

// File: rtl/pic_lowbit.sv
// Isolates the lowest set bit (highest priority) of a vector.
module pic_lowbit #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] one_o
);
    assign one_o = vec_i & (~vec_i + W'(1));
endmodule

// File: rtl/pic_poll_sel.sv
// Chooses the highest-priority pending, unmasked, unblocked source.
module pic_poll_sel #(
    parameter int NSRC = 8,
    parameter int TW   = 5
) (
    input  logic [NSRC-1:0]    pend_i,
    input  logic [NSRC-1:0]    mask_i,
    input  logic [NSRC-1:0]    ins_i,
    input  logic [NSRC*TW-1:0] type_tab_i,
    output logic               found_o,
    output logic [NSRC-1:0]    sel_o,
    output logic [TW-1:0]      type_o
);
    logic [NSRC-1:0] blocked;
    logic [NSRC-1:0] elig;

    assign blocked[0] = ins_i[0];
    for (genvar i = 1; i < NSRC; i++) begin : g_block
        assign blocked[i] = blocked[i-1] | ins_i[i];
    end

    assign elig    = pend_i & ~mask_i & ~blocked;
    assign found_o = |elig;

    pic_lowbit #(.W(NSRC)) u_pick (
        .vec_i (elig),
        .one_o (sel_o)
    );

    always_comb begin
        type_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel_o[i]) type_o = type_o | type_tab_i[i*TW +: TW];
        end
    end
endmodule

// File: rtl/pic_poll_unit.sv
module pic_poll_unit
    import pic_poll_pkg::*;
#(
    parameter int NEXT      = 4,
    parameter int T0_TYPE   = 8,
    parameter int T1_TYPE   = 18,
    parameter int D0_TYPE   = 10,
    parameter int D1_TYPE   = 11,
    parameter int EXT_BASE  = 12,
    localparam int NSRC     = N_ONCHIP + NEXT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_i,
    input  logic [NSRC-1:0]   mask_i,
    input  logic              eoi_i,
    input  logic              rd_en_i,
    input  logic [1:0]        rd_addr_i,
    output logic [WORD_W-1:0] rd_data_o
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] ins;
    } state_t;

    state_t st_d, st_q;

    logic [NSRC*TYPE_W-1:0] type_tab;
    logic                   found;
    logic [NSRC-1:0]        sel_oh;
    logic [TYPE_W-1:0]      sel_type;
    logic [NSRC-1:0]        eoi_oh;
    logic [NSRC-1:0]        ins_q;
    logic                   ack;
    logic [WORD_W-1:0]      poll_word;
    logic [WORD_W-1:0]      mask_word;

    // Type code table: on-chip sources by parameter, externals counted up.
    assign type_tab[0*TYPE_W +: TYPE_W] = TYPE_W'(T0_TYPE);
    assign type_tab[1*TYPE_W +: TYPE_W] = TYPE_W'(T1_TYPE);
    assign type_tab[2*TYPE_W +: TYPE_W] = TYPE_W'(D0_TYPE);
    assign type_tab[3*TYPE_W +: TYPE_W] = TYPE_W'(D1_TYPE);
    for (genvar e = 0; e < NEXT; e++) begin : g_ext_type
        assign type_tab[(N_ONCHIP+e)*TYPE_W +: TYPE_W] = TYPE_W'(EXT_BASE + e);
    end

    pic_poll_sel #(.NSRC(NSRC), .TW(TYPE_W)) u_sel (
        .pend_i     (st_q.pend),
        .mask_i     (mask_i),
        .ins_i      (st_q.ins),
        .type_tab_i (type_tab),
        .found_o    (found),
        .sel_o      (sel_oh),
        .type_o     (sel_type)
    );

    pic_lowbit #(.W(NSRC)) u_eoi (
        .vec_i (st_q.ins),
        .one_o (eoi_oh)
    );

    assign ins_q = st_q.ins;

    always_comb begin
        st_d = st_q;
        ack  = rd_en_i && (rd_addr_i == RA_POLL) && found;

        st_d.pend = (st_q.pend | req_i) & ~(ack ? sel_oh : '0);
        st_d.ins  = (st_q.ins | (ack ? sel_oh : '0)) & ~(eoi_i ? eoi_oh : '0);

        poll_word = {found, 10'd0, (found ? sel_type : {TYPE_W{1'b0}})};

        mask_word    = '0;
        mask_word[0] = mask_i[0];
        mask_word[4] = mask_i[1];
        mask_word[2] = mask_i[2];
        mask_word[3] = mask_i[3];

        case (rd_addr_i)
            RA_MASK: rd_data_o = mask_word;
            RA_STAT: rd_data_o = poll_word;
            RA_POLL: rd_data_o = poll_word;
            default: rd_data_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pic_poll_chk.sv
module pic_poll_chk #(
    parameter int NSRC = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            eoi_i,
    input logic            rd_en_i,
    input logic [1:0]      rd_addr_i,
    input logic [15:0]     rd_data_o,
    input logic [NSRC-1:0] ins_q
);
    AST_WORD_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == 2'd1 || rd_addr_i == 2'd2) |-> rd_data_o[14:5] == 10'd0); // R3

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_addr_i == 2'd1 || rd_addr_i == 2'd2) && !rd_data_o[15]) |-> rd_data_o == 16'd0); // R3

    AST_MASK_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == 2'd0) |-> (rd_data_o[1] == 1'b0 && rd_data_o[15:5] == 11'd0)); // R2

    AST_ACK_INSERV: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == 2'd2 && rd_data_o[15] && !eoi_i)
        |=> $countones(ins_q) == $past($countones(ins_q)) + 1); // R8

    AST_STAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == 2'd1 && !eoi_i) |=> $stable(ins_q)); // R7

    AST_EOI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !(rd_en_i && rd_addr_i == 2'd2) && ins_q != '0)
        |=> $countones(ins_q) == $past($countones(ins_q)) - 1); // R10
endmodule

bind pic_poll_unit pic_poll_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eoi_i     (eoi_i),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .ins_q     (ins_q)
);

// File: tb/sim_pic_poll_unit.sv
`timescale 1ns/1ps
module sim_pic_poll_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req = '0;
    logic [7:0]  mask = '0;
    logic        eoi = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd1;
    logic [15:0] rdata;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pic_poll_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .mask_i    (mask),
        .eoi_i     (eoi),
        .rd_en_i   (rd_en),
        .rd_addr_i (addr),
        .rd_data_o (rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {req, mask, ack, eoi, expected status after the step}
    localparam logic [33:0] VEC [17] = '{
        {8'h00, 8'h00, 1'b0, 1'b0, 16'h0000},
        {8'h20, 8'h00, 1'b0, 1'b0, 16'h800D},
        {8'h08, 8'h00, 1'b0, 1'b0, 16'h800B},
        {8'h02, 8'h02, 1'b0, 1'b0, 16'h800B},
        {8'h00, 8'h00, 1'b0, 1'b0, 16'h8012},
        {8'h00, 8'h00, 1'b1, 1'b0, 16'h0000},
        {8'h01, 8'h00, 1'b0, 1'b0, 16'h8008},
        {8'h00, 8'h00, 1'b1, 1'b0, 16'h0000},
        {8'h00, 8'h00, 1'b0, 1'b1, 16'h0000},
        {8'h00, 8'h00, 1'b0, 1'b1, 16'h800B},
        {8'h04, 8'h00, 1'b1, 1'b0, 16'h800A},
        {8'h00, 8'h00, 1'b1, 1'b0, 16'h0000},
        {8'h00, 8'h00, 1'b0, 1'b1, 16'h0000},
        {8'h00, 8'h00, 1'b0, 1'b1, 16'h800D},
        {8'h00, 8'h20, 1'b0, 1'b0, 16'h0000},
        {8'h00, 8'h00, 1'b1, 1'b0, 16'h0000},
        {8'h00, 8'h00, 1'b0, 1'b1, 16'h0000}
    };

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #2;
        addr = 2'd0; #1 check("R12 reset mask", rdata, 16'h0000);
        addr = 2'd1; #1 check("R12 reset status", rdata, 16'h0000);
        addr = 2'd2; #1 check("R12 reset poll", rdata, 16'h0000);
        addr = 2'd1;

        // Vector walk: R1 R4 R5 R6 R8 R9 R10
        for (int k = 0; k < 17; k++) begin
            @(negedge clk);
            req   = VEC[k][33:26];
            mask  = VEC[k][25:18];
            rd_en = VEC[k][17];
            addr  = VEC[k][17] ? 2'd2 : 2'd1;
            eoi   = VEC[k][16];
            @(negedge clk);
            req = '0; rd_en = 1'b0; eoi = 1'b0; addr = 2'd1;
            #2 check($sformatf("R4 R6 R8 R9 R10 vector %0d", k), rdata, VEC[k][15:0]);
        end

        // R2 mask summary layout
        addr = 2'd0;
        mask = 8'hFF; #1 check("R2 all masked", rdata, 16'h001D);
        mask = 8'h02; #1 check("R2 timer1", rdata, 16'h0010);
        mask = 8'h04; #1 check("R2 dma0", rdata, 16'h0004);
        mask = 8'h08; #1 check("R2 dma1", rdata, 16'h0008);
        mask = 8'h01; #1 check("R2 timer0", rdata, 16'h0001);
        mask = 8'hF0; #1 check("R2 externals absent", rdata, 16'h0000);
        mask = 8'h00; addr = 2'd1;

        // R7 repeated status reads change nothing
        @(negedge clk) req = 8'h40;
        @(negedge clk) req = 8'h00; rd_en = 1'b1; addr = 2'd1;
        for (int k = 0; k < 3; k++) begin
            #2 check("R7 status read", rdata, 16'h800E);
            @(negedge clk);
        end
        rd_en = 1'b0; addr = 2'd2;
        #2 check("R7 poll equals status", rdata, 16'h800E);
        rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0; addr = 2'd1;
        #2 check("R8 advance after poll", rdata, 16'h0000);
        @(negedge clk) eoi = 1'b1;
        @(negedge clk) eoi = 1'b0;

        // R11 empty poll read
        rd_en = 1'b1; addr = 2'd2;
        #2 check("R11 empty poll word", rdata, 16'h0000);
        @(negedge clk) rd_en = 1'b0; req = 8'h10;
        @(negedge clk) req = 8'h00; addr = 2'd1;
        #2 check("R11 no phantom service", rdata, 16'h800C);

        // R12 reset mid-run
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        #2 check("R12 reset clears pending", rdata, 16'h0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule